// File: doc/BRIEF.md
# Falling-Edge Manchester Uplink Decoder

This block rebuilds the bit stream of a transponder's uplink frame. It looks only at the falling edges of the tag's Manchester modulation. An upstream timer measures the spacing between successive falling edges in carrier periods. It hands each spacing to this block as a one-cycle strobe with a length value.

The decoder sorts each length into one of five kinds: glitch, two half-bit periods, three half-bit periods, four half-bit periods, or end-of-frame gap. From that kind and three small pieces of history it appends zero, one or two bits to a packed buffer. The history is the last bit value, a skip toggle and a start-of-frame counter. An end-of-frame gap records the response delay instead.

The consumer reads the buffer, the bit count and the gap. It then pulses `frame_end`, which returns every piece of state to its start value. Results appear on the clock edge that samples the strobe.

Top module: `mdec_tag_decoder`

## Requirements
- R1: After reset, and after every `frame_end`, the outputs are as follows: bit count 0, buffer all zero, gap 0, glitch flag clear, overflow flag clear. The decoder history restarts with last bit 1, skip set and start-of-frame counter at 4.
- R2: With default parameters a strobed length L is classified as follows. L < 28 is a glitch. 28 ≤ L < 40 is two half periods. 40 ≤ L < 56 is three half periods. 56 ≤ L < 72 is four half periods. L ≥ 72 is an end-of-frame gap.
- R3: An end-of-frame gap sets `gap_o` to L − 16 (one half period) and appends no bit. Other kinds leave `gap_o` unchanged.
- R4: A four-half-period interval appends bit 0 and then bit 1.
- R5: A three-half-period interval appends bit 0, then appends bit 1 only when skip is clear. It then inverts both the last-bit value and skip.
- R6: A two-half-period interval appends nothing while the start-of-frame counter is nonzero, and decrements the counter instead. Once the counter is zero, it appends the current last-bit value.
- R7: A glitch appends no bit and sets `glitch_o`, which stays set until `frame_end`.
- R8: The i-th appended bit (counting from 0) appears at `bits_o[159-i]`. Byte 0 therefore occupies `bits_o[159:152]`, with its first bit in the most significant position. `bit_cnt_o` equals the number of stored bits.
- R9: At most 160 bits are stored. Any append that would exceed 160 bits is dropped and sets `ovf_o`, which stays set until `frame_end`. This applies even when the dropped bit is the second bit of a pair.
- R10: `frame_end` has priority: a strobe in the same cycle is discarded, and the state after that edge is the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iv_valid | input | 1 | Strobe: a falling-edge interval is presented |
| iv_len | input | 10 | Interval length in carrier periods |
| frame_end | input | 1 | Closes the frame and restores start state |
| bits_o | output | 160 | Packed decoded bits, first bit at the top |
| bit_cnt_o | output | 8 | Number of stored bits |
| gap_o | output | 10 | Response gap in carrier periods |
| glitch_o | output | 1 | Sticky: an interval shorter than two half periods was seen |
| ovf_o | output | 1 | Sticky: an append was dropped at the 160-bit limit |

## Verification
The assertions assume that `iv_valid` and `frame_end` are single-cycle, synchronous strobes that stay low during reset. They also assume that `iv_len` is meaningful only while `iv_valid` is high. The bench drives both strobes on the falling clock edge and holds each for exactly one cycle. It releases reset before any strobe, and keeps lengths within the 10-bit range. The bench also makes one deliberate collision of `frame_end` with a strobe, which is legal and is covered by R10.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  typedef enum logic [2:0] {
    IV_GLITCH = 3'd0,
    IV_TWO    = 3'd1,
    IV_THREE  = 3'd2,
    IV_FOUR   = 3'd3,
    IV_EOF    = 3'd4
  } iv_kind_e;

  // Ordered threshold comparison, longest class tested first.
  function automatic iv_kind_e iv_classify(input int unsigned len,
                                           input int unsigned t2,
                                           input int unsigned t3,
                                           input int unsigned t4,
                                           input int unsigned teof);
    if (len >= teof)    return IV_EOF;
    else if (len >= t4) return IV_FOUR;
    else if (len >= t3) return IV_THREE;
    else if (len >= t2) return IV_TWO;
    else                return IV_GLITCH;
  endfunction

  // A tag frame opens with a one whose falling edge sits one half period in.
  function automatic int unsigned resp_gap(input int unsigned len,
                                           input int unsigned half);
    return len - half;
  endfunction

endpackage

// File: rtl/mdec_classify.sv
module mdec_classify
  import mdec_pkg::*;
#(
  parameter int IW   = 10,
  parameter int T2   = 28,
  parameter int T3   = 40,
  parameter int T4   = 56,
  parameter int TEOF = 72
) (
  input  logic [IW-1:0] len,
  output iv_kind_e      kind
);

  always_comb begin
    kind = iv_classify(32'(len), 32'(T2), 32'(T3), 32'(T4), 32'(TEOF));
  end

endmodule

// File: rtl/mdec_seq.sv
module mdec_seq
  import mdec_pkg::*;
#(
  parameter int SOF_INIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       step,
  input  iv_kind_e   kind,
  output logic [1:0] app_n,
  output logic       app_b0,
  output logic       app_b1
);

  localparam int SW = $clog2(SOF_INIT + 1);
  localparam logic [SW-1:0] SOF_START = SW'(SOF_INIT);

  logic          last_q, skip_q;
  logic [SW-1:0] sof_q;

  always_comb begin
    app_n  = 2'd0;
    app_b0 = 1'b0;
    app_b1 = 1'b1;
    if (step && !clr) begin
      unique case (kind)
        IV_FOUR:  app_n = 2'd2;
        IV_THREE: app_n = skip_q ? 2'd1 : 2'd2;
        IV_TWO: begin
          app_b0 = last_q;
          app_n  = (sof_q != '0) ? 2'd0 : 2'd1;
        end
        default:  app_n = 2'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b1;
      skip_q <= 1'b1;
      sof_q  <= SOF_START;
    end else if (clr) begin
      last_q <= 1'b1;
      skip_q <= 1'b1;
      sof_q  <= SOF_START;
    end else if (step) begin
      if (kind == IV_THREE) begin
        last_q <= ~last_q;
        skip_q <= ~skip_q;
      end
      if (kind == IV_TWO && sof_q != '0) sof_q <= sof_q - 1'b1;
    end
  end

  AST_SOF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && kind == IV_TWO && sof_q != '0) |-> app_n == 2'd0); // R6
  AST_SKIP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && kind == IV_THREE) |=> (skip_q != $past(skip_q) && last_q != $past(last_q))); // R5
  AST_FOUR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && kind == IV_FOUR) |-> (app_n == 2'd2 && !app_b0 && app_b1)); // R4
  AST_SEQ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (last_q && skip_q && sof_q == SOF_START)); // R1

endmodule

// File: rtl/mdec_pack.sv
module mdec_pack #(
  parameter int MAXBITS = 160,
  parameter int CW      = $clog2(MAXBITS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [1:0]         app_n,
  input  logic               app_b0,
  input  logic               app_b1,
  output logic [MAXBITS-1:0] bits_o,
  output logic [CW-1:0]      cnt_o,
  output logic               ovf_o
);

  localparam logic [CW-1:0] TOP0 = CW'(MAXBITS - 1);
  localparam logic [CW-1:0] TOP1 = CW'(MAXBITS - 2);
  localparam logic [CW-1:0] CAP  = CW'(MAXBITS);

  logic [MAXBITS-1:0] buf_q;
  logic [CW-1:0]      cnt_q;
  logic               ovf_q;
  logic [CW-1:0]      room;
  logic [1:0]         take;
  logic [CW-1:0]      idx0, idx1;
  logic               drop;

  always_comb begin
    room = CAP - cnt_q;
    take = (CW'(app_n) > room) ? room[1:0] : app_n;
    drop = (app_n != take);
    idx0 = TOP0 - cnt_q;
    idx1 = TOP1 - cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr) begin
      buf_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (take != 2'd0) buf_q[idx0] <= app_b0;
      if (take == 2'd2) buf_q[idx1] <= app_b1;
      cnt_q <= cnt_q + CW'(take);
      if (drop) ovf_q <= 1'b1;
    end
  end

  assign bits_o = buf_q;
  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> ovf_q); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q >= $past(cnt_q) && cnt_q <= $past(cnt_q) + CW'(2))); // R8
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !ovf_q && buf_q == '0)); // R10

endmodule

// File: rtl/mdec_tag_decoder.sv
module mdec_tag_decoder
  import mdec_pkg::*;
#(
  parameter int IW       = 10,
  parameter int HALF     = 16,
  parameter int T2       = 28,
  parameter int T3       = 40,
  parameter int T4       = 56,
  parameter int TEOF     = 72,
  parameter int SOF_INIT = 4,
  parameter int MAXBITS  = 160,
  parameter int CW       = $clog2(MAXBITS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iv_valid,
  input  logic [IW-1:0]      iv_len,
  input  logic               frame_end,
  output logic [MAXBITS-1:0] bits_o,
  output logic [CW-1:0]      bit_cnt_o,
  output logic [IW-1:0]      gap_o,
  output logic               glitch_o,
  output logic               ovf_o
);

  iv_kind_e      kind;
  logic          step;
  logic [1:0]    app_n;
  logic          app_b0, app_b1;
  logic [IW-1:0] gap_q;
  logic          glitch_q;

  assign step = iv_valid && !frame_end;

  mdec_classify #(.IW(IW), .T2(T2), .T3(T3), .T4(T4), .TEOF(TEOF)) u_cls (
    .len  (iv_len),
    .kind (kind)
  );

  mdec_seq #(.SOF_INIT(SOF_INIT)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (frame_end),
    .step   (step),
    .kind   (kind),
    .app_n  (app_n),
    .app_b0 (app_b0),
    .app_b1 (app_b1)
  );

  mdec_pack #(.MAXBITS(MAXBITS), .CW(CW)) u_pack (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (frame_end),
    .app_n  (app_n),
    .app_b0 (app_b0),
    .app_b1 (app_b1),
    .bits_o (bits_o),
    .cnt_o  (bit_cnt_o),
    .ovf_o  (ovf_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q    <= '0;
      glitch_q <= 1'b0;
    end else if (frame_end) begin
      gap_q    <= '0;
      glitch_q <= 1'b0;
    end else if (step) begin
      if (kind == IV_EOF)    gap_q <= IW'(resp_gap(32'(iv_len), 32'(HALF)));
      if (kind == IV_GLITCH) glitch_q <= 1'b1;
    end
  end

  assign gap_o    = gap_q;
  assign glitch_o = glitch_q;

  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind != IV_EOF) |=> $stable(gap_o)); // R3
  AST_EOF_NOBITS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind == IV_EOF) |=> $stable(bit_cnt_o)); // R3
  AST_GLITCH_NOBITS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind == IV_GLITCH) |=> ($stable(bit_cnt_o) && glitch_o)); // R7
  AST_END_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (gap_o == '0 && !glitch_o)); // R10

endmodule

// File: tb/tb_mdec_tag_decoder.sv
module tb_mdec_tag_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 160;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iv_valid = 1'b0;
  logic [9:0]    iv_len = '0;
  logic          frame_end = 1'b0;
  logic [NB-1:0] bits_o;
  logic [7:0]    bit_cnt_o;
  logic [9:0]    gap_o;
  logic          glitch_o;
  logic          ovf_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_q[$];
  int m_gap = 0;
  bit m_glitch = 0, m_ovf = 0, m_last = 1, m_skip = 1;
  int m_sof = 4;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdec_tag_decoder dut (
    .clk(clk), .rst_n(rst_n), .iv_valid(iv_valid), .iv_len(iv_len),
    .frame_end(frame_end), .bits_o(bits_o), .bit_cnt_o(bit_cnt_o),
    .gap_o(gap_o), .glitch_o(glitch_o), .ovf_o(ovf_o)
  );

  task automatic m_clear();
    m_q.delete();
    m_gap = 0; m_glitch = 0; m_ovf = 0;
    m_last = 1; m_skip = 1; m_sof = 4;
  endtask

  task automatic m_push(bit b);
    if (m_q.size() < NB) m_q.push_back(b);
    else m_ovf = 1;
  endtask

  task automatic m_apply(int len);
    if (len >= 72) m_gap = len - 16;
    else if (len >= 56) begin m_push(0); m_push(1); end
    else if (len >= 40) begin
      m_push(0);
      if (!m_skip) m_push(1);
      m_last = !m_last; m_skip = !m_skip;
    end else if (len >= 28) begin
      if (m_sof > 0) m_sof--;
      else m_push(m_last);
    end else m_glitch = 1;
  endtask

  task automatic check_field(string what, logic [NB-1:0] act, logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [NB-1:0] ev = '0;
    foreach (m_q[i]) ev[NB-1-i] = m_q[i];
    check_field("bits", bits_o, ev);
    check_field("count", NB'(bit_cnt_o), NB'(m_q.size()));
    check_field("gap", NB'(gap_o), NB'(m_gap));
    check_field("glitch", NB'(glitch_o), NB'(m_glitch));
    check_field("ovf", NB'(ovf_o), NB'(m_ovf));
  endtask

  // compare the state left by the previous edge, then set up the next one
  task automatic step(bit v, int len, bit fe);
    @(negedge clk);
    compare();
    iv_valid = v; iv_len = 10'(len); frame_end = fe;
    if (fe) m_clear();
    else if (v) m_apply(len);
  endtask

  task automatic iv(int len); step(1, len, 0); endtask
  task automatic close(); step(0, 0, 1); endtask
  task automatic idle(); step(0, 0, 0); endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    finished = 1;
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      summary();
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    idle(); idle();

    // R6: start-of-frame two-halves swallowed, then last bit repeated
    cur_req = "R6";
    for (int i = 0; i < 6; i++) iv(32);
    idle();
    close();

    // R5: three-half sequence with skip toggling
    cur_req = "R5";
    iv(48); iv(48); iv(32); iv(48); iv(32); iv(48);
    idle();
    close();

    // R4: four-half pairs
    cur_req = "R4";
    iv(64); iv(64); iv(56); idle();
    close();

    // R3: end-of-frame gap recorded, no bits
    cur_req = "R3";
    iv(100); iv(64); idle(); iv(72); idle();
    close();

    // R2: threshold boundaries
    cur_req = "R2";
    for (int i = 0; i < 4; i++) iv(28);
    iv(39); iv(40); iv(55); iv(56); iv(71); iv(72); iv(27);
    idle();
    close();

    // R7: glitch ignored and sticky
    cur_req = "R7";
    iv(10); iv(0); iv(64); iv(27); idle();
    close();

    // R8: packing across byte lanes
    cur_req = "R8";
    for (int i = 0; i < 4; i++) iv(32);
    for (int i = 0; i < 9; i++) iv((i % 2) ? 60 : 44);
    idle();
    close();

    // R9: overflow on the second bit of a pair
    cur_req = "R9";
    for (int i = 0; i < 5; i++) iv(32);
    for (int i = 0; i < 80; i++) iv(64);
    iv(32); iv(64); idle();
    close();

    // R10: frame end beats a same-cycle strobe
    cur_req = "R10";
    iv(64); iv(20); iv(90);
    step(1, 60, 1);
    idle();
    iv(64); idle();
    close();

    // mixed random traffic exercising all classes
    cur_req = "R8";
    for (int f = 0; f < 6; f++) begin
      for (int i = 0; i < 120; i++) iv(int'($urandom_range(110, 20)));
      idle();
      close();
    end
    idle();
    summary();
  end

endmodule